// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block puts a two-wire handshake around a single 8-bit peripheral data port. A static direction pin picks one of two engines. In output direction, a host write to the data address latches a byte toward the peripheral and drives an active-low full flag low. The peripheral pulls its active-low acknowledge to empty the buffer again. In input direction, the peripheral pulls its active-low strobe to load a byte into an input latch and raise an active-high full flag. A host read of the data address empties it.

Each direction has its own interrupt-enable bit. The host changes it with a single-bit set/clear command written to the control address. The interrupt output tells the host that the port can take its next byte, or that it has a byte waiting. A status read at the control address returns the flags, so that software can poll instead.

Every strobe, including the host's, is brought into the system clock domain through a two-stage synchronizer, and edges are found on the synchronized copies. The data bus carries no valid/ready handshake. The full flag is the only back-pressure, and software must respect it. The host holds the address and write data steady while its strobe is low. The peripheral holds its data steady while its strobe is low.

Top module: `hsp_port_ctrl`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, both enable bits are 0, and a status read returns 0x00.
- R2: In output direction (dir_out=1), a host write to address 0 puts the written byte on periph_dout and drives obf_n low once the trailing (rising) edge of host_wr_n has passed the synchronizer.
- R3: In output direction, periph_ack_n low drives obf_n back to 1, and a later acknowledge leaves periph_dout unchanged.
- R4: In output direction, intr is 1 while the output enable is 1, periph_ack_n is high, obf_n is high and no data write is under way. It drops once host_wr_n goes low for a data write.
- R5: In input direction (dir_out=0), periph_stb_n low loads periph_din into the input latch and sets ibf. A host read of address 0 returns the latched byte.
- R6: In input direction, the trailing edge of a host read of address 0 clears ibf. A read of address 1 leaves ibf set.
- R7: In input direction, intr is 1 while the input enable is 1, ibf is 1, periph_stb_n is high and no data read is under way. It drops once host_rd_n goes low for a data read.
- R8: A write to address 1 whose bit 7 is 0 is a bit command: bits 3:1 name a bit and bit 0 is its new value. Bit 6 is the output-direction enable and bit 4 is the input-direction enable. Other bit numbers, and words with bit 7 set, change neither enable.
- R9: A read of address 1 returns the status word: bit 0 is 1 when the active direction's buffer is full, bit 1 is intr, bit 2 is the active direction's enable, and bits 7:3 are 0.
- R10: Stimulus for the inactive direction is ignored. In input direction, data writes leave periph_dout and obf_n unchanged. In output direction, periph_stb_n leaves obf_n and intr unchanged.
- R11: The input latch holds its byte while periph_stb_n is high, even when periph_din changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Static direction select: 1 output, 0 input |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr | input | 1 | 0 data, 1 control/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (data latch or status word) |
| periph_stb_n | input | 1 | Peripheral load strobe, active low |
| periph_ack_n | input | 1 | Peripheral acknowledge, active low |
| periph_din | input | 8 | Data from the peripheral |
| periph_dout | output | 8 | Latched data toward the peripheral |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full, active high |
| intr | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the checker ties the synchronized events to the flags one cycle later. A data-write trailing edge must fill the output buffer, and an acknowledge must empty it. A load strobe must fill the input buffer, and a data-read trailing edge must empty it. An active data read must hold the interrupt low, and the interrupt may only rise with its enable already set. The directed scenarios cover what needs whole transactions to show: the latched byte values, the bit-command decoding and ignored words, the status layout, and that the idle direction ignores its stimulus.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int HSP_DW = 8;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic [HSP_DW-4:0] rsvd;
    logic              inte;
    logic              intr;
    logic              full;
  } hsp_status_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_out_chan.sv
module hsp_out_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_commit,
  input  logic          wr_busy,
  input  logic [DW-1:0] wdata,
  input  logic          ack_lo,
  input  logic          inte,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          intr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      full <= 1'b0;
      intr <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
      intr <= 1'b0;
    end else begin
      if (wr_commit) dout <= wdata;
      // a fresh byte wins over a coincident acknowledge
      if (wr_commit)   full <= 1'b1;
      else if (ack_lo) full <= 1'b0;
      intr <= inte & ~ack_lo & ~full & ~wr_busy & ~wr_commit;
    end
  end
endmodule

// File: rtl/hsp_in_chan.sv
module hsp_in_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb_lo,
  input  logic [DW-1:0] din,
  input  logic          rd_commit,
  input  logic          rd_busy,
  input  logic          inte,
  output logic [DW-1:0] latch,
  output logic          full,
  output logic          intr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
      full  <= 1'b0;
      intr  <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
      intr <= 1'b0;
    end else begin
      if (stb_lo) begin
        latch <= din;
        full  <= 1'b1;
      end else if (rd_commit) begin
        full <= 1'b0;
      end
      intr <= inte & full & ~stb_lo & ~rd_busy & ~rd_commit;
    end
  end
endmodule

// File: rtl/hsp_cmd.sv
module hsp_cmd #(
  parameter int DW      = 8,
  parameter int OUT_BIT = 6,
  parameter int IN_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [DW-1:0] word,
  output logic          inte_out,
  output logic          inte_in
);
  localparam int IDX_W = $clog2(DW);

  logic [IDX_W-1:0] idx;
  logic             is_bitcmd;
  logic             unused_word;

  assign idx         = word[IDX_W:1];
  assign is_bitcmd   = commit & ~word[DW-1];
  assign unused_word = ^word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_out <= 1'b0;
      inte_in  <= 1'b0;
    end else if (is_bitcmd) begin
      if (idx == IDX_W'(OUT_BIT)) inte_out <= word[0];
      if (idx == IDX_W'(IN_BIT))  inte_in  <= word[0];
    end
  end
endmodule

// File: rtl/hsp_port_ctrl.sv
module hsp_port_ctrl
  import hsp_pkg::*;
#(
  parameter int DW       = HSP_DW,
  parameter int SYNC_STG = 2,
  parameter int OUT_BIT  = 6,
  parameter int IN_BIT   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_out,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic          host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          periph_stb_n,
  input  logic          periph_ack_n,
  input  logic [DW-1:0] periph_din,
  output logic [DW-1:0] periph_dout,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr
);
  localparam int NSTRB = 4;

  logic [NSTRB-1:0] strb_raw, strb_s;
  logic wr_s, rd_s, stb_s, ack_s;
  logic wr_q, rd_q;
  logic wr_addr_h, rd_addr_h;
  logic [DW-1:0] wr_data_h;
  logic [DW-1:0] din_pipe [SYNC_STG];

  assign strb_raw = {host_wr_n, host_rd_n, periph_stb_n, periph_ack_n};

  hsp_sync #(.W(NSTRB), .STAGES(SYNC_STG), .RST_VAL({NSTRB{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );
  assign {wr_s, rd_s, stb_s, ack_s} = strb_s;

  // capture address and data while the raw strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      wr_addr_h <= ADDR_DATA;
      rd_addr_h <= ADDR_DATA;
      wr_data_h <= '0;
      for (int i = 0; i < SYNC_STG; i++) din_pipe[i] <= '0;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
      if (!host_wr_n) begin
        wr_addr_h <= host_addr;
        wr_data_h <= host_wdata;
      end
      if (!host_rd_n) rd_addr_h <= host_addr;
      din_pipe[0] <= periph_din;
      for (int i = 1; i < SYNC_STG; i++) din_pipe[i] <= din_pipe[i-1];
    end
  end

  logic wr_rise, rd_rise;
  logic wr_data_rise, wr_data_busy, wr_cmd_rise;
  logic rd_data_rise, rd_data_busy;
  logic stb_lo, ack_lo;

  assign wr_rise      = wr_s & ~wr_q;
  assign rd_rise      = rd_s & ~rd_q;
  assign wr_data_rise = wr_rise & (wr_addr_h == ADDR_DATA) & dir_out;
  assign wr_data_busy = ~wr_s & (wr_addr_h == ADDR_DATA) & dir_out;
  assign wr_cmd_rise  = wr_rise & (wr_addr_h == ADDR_CTRL);
  assign rd_data_rise = rd_rise & (rd_addr_h == ADDR_DATA) & ~dir_out;
  assign rd_data_busy = ~rd_s & (rd_addr_h == ADDR_DATA) & ~dir_out;
  assign stb_lo       = ~stb_s;
  assign ack_lo       = ~ack_s;

  logic inte_out, inte_in, inte_cur;

  hsp_cmd #(.DW(DW), .OUT_BIT(OUT_BIT), .IN_BIT(IN_BIT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .commit(wr_cmd_rise), .word(wr_data_h),
    .inte_out(inte_out), .inte_in(inte_in)
  );
  assign inte_cur = dir_out ? inte_out : inte_in;

  logic [DW-1:0] out_latch, in_latch;
  logic out_full, out_intr, in_full, in_intr;

  hsp_out_chan #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .en(dir_out),
    .wr_commit(wr_data_rise), .wr_busy(wr_data_busy), .wdata(wr_data_h),
    .ack_lo(ack_lo), .inte(inte_out),
    .dout(out_latch), .full(out_full), .intr(out_intr)
  );

  hsp_in_chan #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .en(~dir_out),
    .stb_lo(stb_lo), .din(din_pipe[SYNC_STG-1]),
    .rd_commit(rd_data_rise), .rd_busy(rd_data_busy), .inte(inte_in),
    .latch(in_latch), .full(in_full), .intr(in_intr)
  );

  hsp_status_t stat;
  always_comb begin
    stat      = '0;
    stat.full = dir_out ? out_full : in_full;
    stat.intr = intr;
    stat.inte = inte_cur;
  end

  assign intr        = dir_out ? out_intr : in_intr;
  assign obf_n       = ~out_full;
  assign ibf         = in_full;
  assign periph_dout = out_latch;
  assign host_rdata  = (host_addr == ADDR_CTRL) ? DW'(stat) :
                       (dir_out ? out_latch : in_latch);
endmodule

// File: rtl/hsp_port_ctrl_chk.sv
module hsp_port_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_out,
  input logic wr_data_rise,
  input logic rd_data_rise,
  input logic rd_data_busy,
  input logic ack_lo,
  input logic stb_lo,
  input logic inte_cur,
  input logic obf_n,
  input logic ibf,
  input logic intr
);
  // R2
  out_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_rise |=> !obf_n);

  // R3
  out_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && ack_lo && !wr_data_rise) |=> obf_n);

  // R5
  in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && stb_lo) |=> ibf);

  // R6
  in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_rise && !stb_lo) |=> !ibf);

  // R7
  in_intr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_busy |=> !intr);

  // R4
  intr_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && $stable(dir_out)) |-> $past(inte_cur));
endmodule

bind hsp_port_ctrl hsp_port_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
  .wr_data_rise(wr_data_rise), .rd_data_rise(rd_data_rise),
  .rd_data_busy(rd_data_busy), .ack_lo(ack_lo), .stb_lo(stb_lo),
  .inte_cur(inte_cur), .obf_n(obf_n), .ibf(ibf), .intr(intr)
);

// File: tb/hsp_port_ctrl_tb.sv
module hsp_port_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_out = 1'b1;
  logic host_wr_n = 1'b1, host_rd_n = 1'b1, host_addr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic periph_stb_n = 1'b1, periph_ack_n = 1'b1;
  logic [7:0] periph_din = '0, periph_dout;
  logic obf_n, ibf, intr;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsp_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
    .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .periph_stb_n(periph_stb_n), .periph_ack_n(periph_ack_n),
    .periph_din(periph_din), .periph_dout(periph_dout),
    .obf_n(obf_n), .ibf(ibf), .intr(intr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    idle(3);
    host_wr_n = 1'b1;
    idle(6);
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd_n = 1'b0;
    idle(3);
    d = host_rdata;
    host_rd_n = 1'b1;
    idle(6);
  endtask

  task automatic pulse_stb(input logic [7:0] d);
    @(negedge clk);
    periph_din = d; periph_stb_n = 1'b0;
    idle(3);
    periph_stb_n = 1'b1;
    idle(6);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    periph_ack_n = 1'b0;
    idle(3);
    periph_ack_n = 1'b1;
    idle(6);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 obf_n", {7'b0, obf_n}, 8'h01);
    check("R1 ibf", {7'b0, ibf}, 8'h00);
    check("R1 intr", {7'b0, intr}, 8'h00);
    host_read(1'b1, r);
    check("R1 status", r, 8'h00);
  endtask

  task automatic t_out_flow();
    logic [7:0] r;
    host_write(1'b0, 8'hA5);
    check("R2 dout", periph_dout, 8'hA5);
    check("R2 obf_n", {7'b0, obf_n}, 8'h00);
    host_read(1'b0, r);
    check("R2 readback", r, 8'hA5);
    pulse_ack();
    check("R3 obf_n", {7'b0, obf_n}, 8'h01);
    check("R3 dout", periph_dout, 8'hA5);
  endtask

  task automatic t_out_intr();
    logic [7:0] r;
    host_write(1'b1, 8'h0D);           // bit 6 := 1
    check("R4 intr empty", {7'b0, intr}, 8'h01);
    host_read(1'b1, r);
    check("R9 status out", r, 8'h06);
    @(negedge clk);
    host_addr = 1'b0; host_wdata = 8'h3E; host_wr_n = 1'b0;
    idle(4);
    check("R4 intr drop", {7'b0, intr}, 8'h00);
    host_wr_n = 1'b1;
    idle(6);
    check("R4 intr full", {7'b0, intr}, 8'h00);
    host_read(1'b1, r);
    check("R9 status full", r, 8'h05);
    pulse_ack();
    check("R4 intr back", {7'b0, intr}, 8'h01);
  endtask

  task automatic t_cmd();
    host_write(1'b1, 8'h8C);           // bit 7 set: ignored
    check("R8 bit7 word", {7'b0, intr}, 8'h01);
    host_write(1'b1, 8'h0A);           // bit 5: no enable
    check("R8 other bit", {7'b0, intr}, 8'h01);
    host_write(1'b1, 8'h08);           // bit 4 := 0, output enable kept
    check("R8 in bit", {7'b0, intr}, 8'h01);
    host_write(1'b1, 8'h0C);           // bit 6 := 0
    check("R8 clear", {7'b0, intr}, 8'h00);
  endtask

  task automatic t_out_ignores_stb();
    pulse_stb(8'h11);
    check("R10 stb obf_n", {7'b0, obf_n}, 8'h01);
    check("R10 stb intr", {7'b0, intr}, 8'h00);
  endtask

  task automatic t_in_flow();
    logic [7:0] r;
    dir_out = 1'b0;
    idle(4);
    host_write(1'b0, 8'h77);
    check("R10 wr dout", periph_dout, 8'hA5 ^ 8'hA5 ^ 8'h3E);
    check("R10 wr obf_n", {7'b0, obf_n}, 8'h01);
    pulse_stb(8'h3C);
    check("R5 ibf", {7'b0, ibf}, 8'h01);
    @(negedge clk);
    periph_din = 8'hFF;
    idle(4);
    host_read(1'b1, r);
    check("R6 status keeps", {7'b0, ibf}, 8'h01);
    check("R9 status in", r, 8'h01);
    host_read(1'b0, r);
    check("R11 latch", r, 8'h3C);
    check("R6 ibf clear", {7'b0, ibf}, 8'h00);
  endtask

  task automatic t_in_intr();
    logic [7:0] r;
    host_write(1'b1, 8'h09);           // bit 4 := 1
    check("R7 intr idle", {7'b0, intr}, 8'h00);
    pulse_stb(8'h5A);
    check("R7 intr set", {7'b0, intr}, 8'h01);
    host_read(1'b1, r);
    check("R9 status in intr", r, 8'h07);
    @(negedge clk);
    host_addr = 1'b0; host_rd_n = 1'b0;
    idle(4);
    check("R7 intr drop", {7'b0, intr}, 8'h00);
    check("R5 read data", host_rdata, 8'h5A);
    host_rd_n = 1'b1;
    idle(6);
    check("R7 after read", {7'b0, intr}, 8'h00);
    check("R6 after read", {7'b0, ibf}, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_out_flow();
    t_out_intr();
    t_cmd();
    t_out_ignores_stb();
    t_in_flow();
    t_in_intr();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule